// File: doc/BRIEF.md
# Dual-Level Overcurrent Circuit Breaker

This block protects the two main supply rails of one slot. For each rail it takes digitized comparator flags from the analog front end. One flag says that the rail has reached its regulation current limit. Two more flags say that the current has crossed a lower or an upper fast-trip level. The block also takes slot-wide flags for thermal shutdown and input undervoltage.

A rail that sits in current limit starts a per-rail filter timer. The breaker trips only if the rail stays in limit for longer than the programmed filter count. A crossing of the selected fast-trip level trips the breaker on the next clock edge, with no filter delay. Thermal shutdown and undervoltage trip the breaker in the same way.

Any trip latches. It shuts down both main rails together and records the cause and the offending rail for a management reader. The latch is released by a clear pulse, but only once no live fault remains. A bypass input suppresses the overcurrent and undervoltage protections for diagnostics. It does not suppress thermal shutdown.

Top module: `dual_oc_breaker`

## Requirements
- R1: `in_limit[i]` is high in the same cycle that `lim_hit[i]` is high, provided `bypass` is low and the breaker is not tripped. Otherwise it is low.
- R2: With filter count N on `filt_limit`, a rail whose `lim_hit` is sampled high on N+1 consecutive rising edges trips the breaker at the last of those edges. With N = 0 it trips at the first edge.
- R3: If `lim_hit` of a rail is sampled low on any edge, that rail's filter timer restarts from zero. A run that is interrupted before completion does not trip.
- R4: `fast_sel` selects the fast-trip flag. 0 and 3 mean disabled. 1 selects `fast_lo_hit`. 2 selects `fast_hi_hit`. A selected flag that is high trips the breaker at the next rising edge. An unselected flag has no effect.
- R5: While `brk_trip` is high, every bit of `rail_off` is high, so both main rails are shut down whichever rail faulted.
- R6: `therm_flt` high trips the breaker at the next rising edge, even while `bypass` is high.
- R7: `uv_flt` high trips the breaker at the next rising edge while `bypass` is low.
- R8: While `bypass` is high, `lim_hit`, the fast-trip flags and `uv_flt` cause no trip. The filter timers are held at zero during bypass, so a full N+1 edge run is needed after bypass is released.
- R9: A trip stays latched until `clr` is sampled high on an edge where no live fault is present. A live fault is thermal, undervoltage not bypassed, or a selected fast flag not bypassed. A clear pulse while a live fault is present is ignored, and a trip condition wins over `clr` when the breaker is not yet tripped.
- R10: At the trip edge, `trip_cause` records the cause: 1 = slow (filtered limit), 2 = fast, 3 = undervoltage, 4 = thermal. The priority is thermal > undervoltage > fast > slow. `trip_rail` records the lowest-index rail carrying that cause, or 0 for slot-wide causes. Both fields hold while tripped and return to 0 on a successful clear.
- R11: After reset, `brk_trip`, `rail_off`, `trip_cause` and `trip_rail` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_limit | input | CNT_W | Filter count N for the slow trip |
| fast_sel | input | 2 | Fast-trip level select (0/3 off, 1 low, 2 high) |
| lim_hit | input | NUM_RAILS | Per-rail regulation threshold reached |
| fast_lo_hit | input | NUM_RAILS | Per-rail lower fast-trip level crossed |
| fast_hi_hit | input | NUM_RAILS | Per-rail upper fast-trip level crossed |
| therm_flt | input | 1 | Thermal shutdown flag |
| uv_flt | input | 1 | Input undervoltage flag |
| bypass | input | 1 | Protection bypass (overcurrent and undervoltage ignored) |
| clr | input | 1 | Trip clear request |
| in_limit | output | NUM_RAILS | Per-rail in-current-limit indication |
| rail_off | output | NUM_RAILS | Main rail shutdown, all set on a trip |
| brk_trip | output | 1 | Latched breaker trip |
| trip_cause | output | 3 | Recorded trip cause code |
| trip_rail | output | RAIL_W | Recorded rail index of the trip |

## Verification
`in_limit` is combinational, so the bench checks it in the same cycle as the flag change. Every trip, clear and status update appears one register stage after the sampling edge. A slow trip appears only after the (N+1)-th consecutive high sample. The bench drives every input on the falling edge and counts rising edges explicitly. It reads the results at the next falling edge: just before the trip edge it expects no trip, and just after that edge it expects the trip and its recorded cause.

// File: rtl/obc_pkg.sv
package obc_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_SLOW  = 3'd1,
    CAUSE_FAST  = 3'd2,
    CAUSE_UV    = 3'd3,
    CAUSE_THERM = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    FSEL_OFF  = 2'd0,
    FSEL_LOW  = 2'd1,
    FSEL_HIGH = 2'd2,
    FSEL_OFF3 = 2'd3
  } fsel_e;

  // choose which fast-trip comparator output counts
  function automatic logic fast_pick(logic [1:0] sel, logic lo, logic hi);
    case (fsel_e'(sel))
      FSEL_LOW:  return lo;
      FSEL_HIGH: return hi;
      default:   return 1'b0;
    endcase
  endfunction

  // filter window complete: flag still high and count reached the limit
  function automatic logic filt_done(logic flag, logic [31:0] cnt, logic [31:0] lim);
    return flag && (cnt >= lim);
  endfunction

endpackage

// File: rtl/obc_filter_timer.sv
module obc_filter_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lim_hit,
  input  logic             hold,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  import obc_pkg::*;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (hold || !lim_hit) cnt <= '0;
    else if (cnt < limit)      cnt <= cnt + 1'b1;
  end

  assign expired = !hold && filt_done(lim_hit, 32'(cnt), 32'(limit));

  // R3
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $past(lim_hit));

endmodule

// File: rtl/obc_rail_guard.sv
module obc_rail_guard #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] limit,
  input  logic [1:0]       fast_sel,
  input  logic             lim_hit,
  input  logic             fast_lo,
  input  logic             fast_hi,
  input  logic             bypass,
  input  logic             tripped,
  output logic             in_limit,
  output logic             slow_fire,
  output logic             fast_fire
);
  import obc_pkg::*;

  logic hold;
  assign hold = bypass || tripped;

  obc_filter_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .lim_hit (lim_hit),
    .hold    (hold),
    .limit   (limit),
    .expired (slow_fire)
  );

  assign fast_fire = !bypass && fast_pick(fast_sel, fast_lo, fast_hi);
  assign in_limit  = lim_hit && !hold;

endmodule

// File: rtl/obc_trip_latch.sv
module obc_trip_latch #(
  parameter int NUM_RAILS = 2,
  localparam int RAIL_W = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 therm_v,
  input  logic                 uv_v,
  input  logic [NUM_RAILS-1:0] fast_v,
  input  logic [NUM_RAILS-1:0] slow_v,
  input  logic                 clr,
  output logic                 trip,
  output logic [2:0]           cause,
  output logic [RAIL_W-1:0]    rail
);
  import obc_pkg::*;

  logic              live_fault, any_fault;
  cause_e            nxt_cause;
  logic [RAIL_W-1:0] nxt_rail, fast_idx, slow_idx;

  assign live_fault = therm_v || uv_v || (|fast_v);
  assign any_fault  = live_fault || (|slow_v);

  always_comb begin
    fast_idx = '0;
    slow_idx = '0;
    for (int i = NUM_RAILS - 1; i >= 0; i--) begin
      if (fast_v[i]) fast_idx = RAIL_W'(i);
      if (slow_v[i]) slow_idx = RAIL_W'(i);
    end
  end

  always_comb begin
    nxt_cause = CAUSE_NONE;
    nxt_rail  = '0;
    if (therm_v)           nxt_cause = CAUSE_THERM;
    else if (uv_v)         nxt_cause = CAUSE_UV;
    else if (|fast_v) begin
      nxt_cause = CAUSE_FAST;
      nxt_rail  = fast_idx;
    end else if (|slow_v) begin
      nxt_cause = CAUSE_SLOW;
      nxt_rail  = slow_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip  <= 1'b0;
      cause <= CAUSE_NONE;
      rail  <= '0;
    end else if (trip) begin
      if (clr && !live_fault) begin
        trip  <= 1'b0;
        cause <= CAUSE_NONE;
        rail  <= '0;
      end
    end else if (any_fault) begin
      trip  <= 1'b1;
      cause <= nxt_cause;
      rail  <= nxt_rail;
    end
  end

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !clr) |=> trip);

  // R9
  clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && live_fault) |=> (trip && $stable(cause)));

  // R10
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> (cause != CAUSE_NONE));

  // R10
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && $past(trip)) |-> ($stable(cause) && $stable(rail)));

endmodule

// File: rtl/dual_oc_breaker.sv
module dual_oc_breaker #(
  parameter int NUM_RAILS = 2,
  parameter int CNT_W     = 16,
  localparam int RAIL_W   = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     filt_limit,
  input  logic [1:0]           fast_sel,
  input  logic [NUM_RAILS-1:0] lim_hit,
  input  logic [NUM_RAILS-1:0] fast_lo_hit,
  input  logic [NUM_RAILS-1:0] fast_hi_hit,
  input  logic                 therm_flt,
  input  logic                 uv_flt,
  input  logic                 bypass,
  input  logic                 clr,
  output logic [NUM_RAILS-1:0] in_limit,
  output logic [NUM_RAILS-1:0] rail_off,
  output logic                 brk_trip,
  output logic [2:0]           trip_cause,
  output logic [RAIL_W-1:0]    trip_rail
);

  logic [NUM_RAILS-1:0] slow_fire, fast_fire;
  logic                 uv_v;

  assign uv_v = uv_flt && !bypass;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    obc_rail_guard #(.CNT_W(CNT_W)) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .limit     (filt_limit),
      .fast_sel  (fast_sel),
      .lim_hit   (lim_hit[g]),
      .fast_lo   (fast_lo_hit[g]),
      .fast_hi   (fast_hi_hit[g]),
      .bypass    (bypass),
      .tripped   (brk_trip),
      .in_limit  (in_limit[g]),
      .slow_fire (slow_fire[g]),
      .fast_fire (fast_fire[g])
    );
  end

  obc_trip_latch #(.NUM_RAILS(NUM_RAILS)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .therm_v (therm_flt),
    .uv_v    (uv_v),
    .fast_v  (fast_fire),
    .slow_v  (slow_fire),
    .clr     (clr),
    .trip    (brk_trip),
    .cause   (trip_cause),
    .rail    (trip_rail)
  );

  assign rail_off = {NUM_RAILS{brk_trip}};

  // R6
  therm_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_flt |=> brk_trip);

  // R8
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !therm_flt && !brk_trip) |=> !brk_trip);

  // R7
  uv_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flt && !bypass) |=> brk_trip);

endmodule

// File: tb/dual_oc_breaker_bench.sv
`timescale 1ns/1ps
module dual_oc_breaker_bench;
  localparam int NR = 2;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] filt_limit = '0;
  logic [1:0]    fast_sel = '0;
  logic [NR-1:0] lim_hit = '0, fast_lo_hit = '0, fast_hi_hit = '0;
  logic          therm_flt = 1'b0, uv_flt = 1'b0, bypass = 1'b0, clr = 1'b0;
  logic [NR-1:0] in_limit, rail_off;
  logic          brk_trip;
  logic [2:0]    trip_cause;
  logic          trip_rail;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dual_oc_breaker #(.NUM_RAILS(NR), .CNT_W(CW)) u_dual_oc_breaker (
    .clk(clk), .rst_n(rst_n), .filt_limit(filt_limit), .fast_sel(fast_sel),
    .lim_hit(lim_hit), .fast_lo_hit(fast_lo_hit), .fast_hi_hit(fast_hi_hit),
    .therm_flt(therm_flt), .uv_flt(uv_flt), .bypass(bypass), .clr(clr),
    .in_limit(in_limit), .rail_off(rail_off), .brk_trip(brk_trip),
    .trip_cause(trip_cause), .trip_rail(trip_rail)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_clear();
    lim_hit = '0; fast_lo_hit = '0; fast_hi_hit = '0;
    therm_flt = 0; uv_flt = 0; clr = 1;
    step(1);
    clr = 0;
    chk("R9 clear trip", brk_trip, 0);
    chk("R10 clear cause", trip_cause, 0);
  endtask

  task automatic t_reset();
    chk("R11 trip", brk_trip, 0);
    chk("R11 rail_off", rail_off, 0);
    chk("R11 cause", trip_cause, 0);
    chk("R11 rail", trip_rail, 0);
  endtask

  task automatic t_limit_flag();
    lim_hit = 2'b10; #1;
    chk("R1 in_limit", in_limit, 2);
    bypass = 1; #1;
    chk("R1 in_limit bypass", in_limit, 0);
    bypass = 0; lim_hit = 0;
    step(1);
  endtask

  task automatic t_slow_trip();
    filt_limit = 4; lim_hit = 2'b10;
    step(4);
    chk("R2 before window", brk_trip, 0);
    step(1);
    chk("R2 trip", brk_trip, 1);
    chk("R10 slow cause", trip_cause, 1);
    chk("R10 slow rail", trip_rail, 1);
    chk("R5 rail_off", rail_off, 3);
    chk("R1 in_limit tripped", in_limit, 0);
    do_clear();
  endtask

  task automatic t_interrupt();
    filt_limit = 4; lim_hit = 2'b01;
    step(4);
    chk("R3 run1", brk_trip, 0);
    lim_hit = 0; step(1);
    chk("R3 gap", brk_trip, 0);
    lim_hit = 2'b01; step(4);
    chk("R3 run2", brk_trip, 0);
    step(1);
    chk("R3 trip", brk_trip, 1);
    chk("R10 rail0", trip_rail, 0);
    do_clear();
  endtask

  task automatic t_fast();
    filt_limit = 100;
    fast_sel = 0; fast_lo_hit = 2'b11; fast_hi_hit = 2'b11;
    step(3);
    chk("R4 sel0 off", brk_trip, 0);
    fast_lo_hit = 0; fast_hi_hit = 2'b01; fast_sel = 1;
    step(2);
    chk("R4 sel1 hi ignored", brk_trip, 0);
    fast_lo_hit = 2'b01; step(1);
    chk("R4 sel1 trip", brk_trip, 1);
    chk("R10 fast cause", trip_cause, 2);
    chk("R10 fast rail0", trip_rail, 0);
    do_clear();
    fast_sel = 2; fast_lo_hit = 2'b10;
    step(2);
    chk("R4 sel2 lo ignored", brk_trip, 0);
    fast_hi_hit = 2'b10; step(1);
    chk("R4 sel2 trip", brk_trip, 1);
    chk("R10 fast rail1", trip_rail, 1);
    do_clear();
    fast_sel = 3; fast_lo_hit = 2'b11; fast_hi_hit = 2'b11;
    step(3);
    chk("R4 sel3 off", brk_trip, 0);
    fast_lo_hit = 0; fast_hi_hit = 0;
  endtask

  task automatic t_priority();
    filt_limit = 0; fast_sel = 2;
    lim_hit = 2'b01; fast_hi_hit = 2'b10;
    step(1);
    chk("R10 fast over slow", trip_cause, 2);
    chk("R10 fast rail", trip_rail, 1);
    do_clear();
    lim_hit = 2'b10; step(1);
    chk("R2 limit zero", brk_trip, 1);
    chk("R10 slow rail1", trip_rail, 1);
    do_clear();
    therm_flt = 1; uv_flt = 1; fast_hi_hit = 2'b01;
    step(1);
    chk("R10 therm first", trip_cause, 4);
    clr = 1; step(1);
    chk("R9 clr blocked therm", brk_trip, 1);
    therm_flt = 0; step(1);
    chk("R9 clr blocked uv", brk_trip, 1);
    chk("R10 cause held", trip_cause, 4);
    uv_flt = 0; step(1);
    chk("R9 clr blocked fast", brk_trip, 1);
    clr = 0;
    do_clear();
    fast_hi_hit = 2'b01; clr = 1; step(1);
    chk("R9 set wins over clr", brk_trip, 1);
    clr = 0;
    do_clear();
  endtask

  task automatic t_bypass();
    filt_limit = 4; fast_sel = 1; bypass = 1; uv_flt = 1;
    lim_hit = 2'b11; fast_lo_hit = 2'b11; fast_hi_hit = 2'b11;
    step(10);
    chk("R8 no trip", brk_trip, 0);
    chk("R8 in_limit", in_limit, 0);
    therm_flt = 1; step(1);
    chk("R6 therm trip", brk_trip, 1);
    chk("R6 therm cause", trip_cause, 4);
    therm_flt = 0; clr = 1; step(1);
    chk("R8 uv ignored by clr", brk_trip, 0);
    clr = 0; fast_lo_hit = 0; fast_hi_hit = 0; uv_flt = 0;
    lim_hit = 2'b01; bypass = 0;
    step(4);
    chk("R8 timer restarted", brk_trip, 0);
    step(1);
    chk("R8 full run trip", brk_trip, 1);
    do_clear();
    uv_flt = 1; step(1);
    chk("R7 uv trip", brk_trip, 1);
    chk("R7 uv cause", trip_cause, 3);
    chk("R10 uv rail", trip_rail, 0);
    do_clear();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_limit_flag();
    t_slow_trip();
    t_interrupt();
    t_fast();
    t_priority();
    t_bypass();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule